// File: doc/BRIEF.md
# Burst Configuration Register Loader

This block holds the 16-bit word that sets up burst reads on a flash-style bus interface, together with the small command sequencer that writes it. Software loads the word with two bus writes. The first write carries a setup code on the data byte. The second write carries a confirm code on the data byte, and the new register value travels on the low sixteen address lines of that same write. Any address bits above those sixteen play no part.

If the second write carries anything other than the confirm code, the sequence is abandoned. The register keeps its old value, and two sticky error flags in the status byte are raised. The interface also tracks whether a read should return the memory array or the status byte. A few plain commands move it between those two modes, and another command clears the error flags. The stored word is presented whole and also split into its fields: burst length, wrap type, Y latency, X latency and the asynchronous-read select.

The write port is a plain strobe with no back-pressure: every cycle in which `wr_en` is high is one bus write and is always taken. All outputs are registered and change on the clock edge that samples the write.

Top module: `bcr_writer`

## Requirements
- R1: After reset, `cfg_word` equals the parameter CFG_RESET (default 16'hB807, bit 15 = 1 selecting asynchronous reads), both error flags are 0, `rd_status_sel` is 0 (array mode) and no sequence is pending.
- R2: A write of the setup code (default 8'h60) while nothing is pending starts a sequence, sets `rd_status_sel` to 1 and leaves `cfg_word` unchanged.
- R3: The next write after setup that carries the confirm code (default 8'h03) loads `cfg_word` with `wr_addr[15:0]` (bit n from address bit n); address bits 16 and above have no effect.
- R4: A confirmed load returns the interface to array mode (`rd_status_sel` = 0) and ends the sequence.
- R5: A write after setup with any data code other than confirm ends the sequence, leaves `cfg_word` unchanged, sets status bits 4 and 5 to 1 and sets `rd_status_sel` to 1.
- R6: The status byte reads bit 7 = 1 (ready), bits 5 and 4 = the error flags, all other bits 0; the error flags stay set through later sequences and are cleared only by the clear-status code (default 8'h50) written while no sequence is pending, which changes neither `cfg_word` nor the read mode.
- R7: Cycles with `wr_en` low change nothing; a pending sequence survives any number of them.
- R8: With no sequence pending, the confirm code and any code not listed in R2, R6 or R10 are ignored: `cfg_word`, the read mode and the status byte all stay as they were.
- R9: Field outputs follow the stored word: `burst_len` = bits 2:0, `burst_wrap` = bit 3, `y_lat` = bits 10:9, `x_lat` = bits 14:11, `async_rd` = bit 15.
- R10: With no sequence pending, code 8'hFF selects array mode (`rd_status_sel` = 0) and code 8'h70 selects status mode (`rd_status_sel` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_data | input | 8 | Command code of the write |
| wr_addr | input | ADDR_W (20) | Write address; low 16 bits carry the new register value on confirm |
| cfg_word | output | 16 | Stored burst configuration word |
| burst_len | output | 3 | Burst length field |
| burst_wrap | output | 1 | Burst wrap type field |
| y_lat | output | 2 | Y latency field |
| x_lat | output | 4 | X latency field |
| async_rd | output | 1 | 1 selects asynchronous reads |
| status | output | 8 | Status byte (ready and sticky error flags) |
| rd_status_sel | output | 1 | 1 when reads return the status byte, 0 for the array |

## Verification
The assertions assume that `wr_data` and `wr_addr` are defined and held steady through each cycle in which `wr_en` is high. They also assume that reset is applied before the first write, so the pending flag starts from a known state. The bench changes inputs only on the falling clock edge, holds each write for one full cycle, and lowers `wr_en` before the next edge. It therefore never presents a half-formed write, and every code it sweeps arrives either in the idle state or in the pending state.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int CFG_W  = 16;
  localparam int DATA_W = 8;

  // Field layout of the configuration word
  localparam int LEN_LO   = 0;
  localparam int LEN_W    = 3;
  localparam int WRAP_POS = 3;
  localparam int YLAT_LO  = 9;
  localparam int YLAT_W   = 2;
  localparam int XLAT_LO  = 11;
  localparam int XLAT_W   = 4;
  localparam int ASYNC_POS = 15;

  // Status byte layout
  localparam int STS_READY_POS = 7;
  localparam int STS_ERR_LO    = 4;
  localparam int STS_ERR_N     = 2;

  typedef enum logic [2:0] {
    K_NONE,
    K_SETUP,
    K_CONFIRM,
    K_RD_ARRAY,
    K_RD_STATUS,
    K_CLR_STATUS
  } cmd_kind_e;

  typedef enum logic {
    MODE_ARRAY  = 1'b0,
    MODE_STATUS = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/bcr_cmd_decode.sv
module bcr_cmd_decode
  import bcr_pkg::*;
#(
  parameter logic [DATA_W-1:0] CODE_SETUP   = 8'h60,
  parameter logic [DATA_W-1:0] CODE_CONFIRM = 8'h03,
  parameter logic [DATA_W-1:0] CODE_RD_ARR  = 8'hFF,
  parameter logic [DATA_W-1:0] CODE_RD_STS  = 8'h70,
  parameter logic [DATA_W-1:0] CODE_CLR_STS = 8'h50
) (
  input  logic [DATA_W-1:0] code,
  output cmd_kind_e         kind
);

  always_comb begin
    if (code == CODE_SETUP)        kind = K_SETUP;
    else if (code == CODE_CONFIRM) kind = K_CONFIRM;
    else if (code == CODE_RD_ARR)  kind = K_RD_ARRAY;
    else if (code == CODE_RD_STS)  kind = K_RD_STATUS;
    else if (code == CODE_CLR_STS) kind = K_CLR_STATUS;
    else                           kind = K_NONE;
  end

endmodule

// File: rtl/bcr_seq_fsm.sv
module bcr_seq_fsm
  import bcr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cmd_kind_e kind,
  output logic      pending,
  output rd_mode_e  mode,
  output logic      load_cfg,
  output logic      set_err,
  output logic      clr_err
);

  logic     pending_d;
  rd_mode_e mode_d;

  always_comb begin
    load_cfg  = 1'b0;
    set_err   = 1'b0;
    clr_err   = 1'b0;
    pending_d = pending;
    mode_d    = mode;
    if (wr_en) begin
      if (pending) begin
        pending_d = 1'b0;
        if (kind == K_CONFIRM) begin
          load_cfg = 1'b1;
          mode_d   = MODE_ARRAY;
        end else begin
          set_err  = 1'b1;
          mode_d   = MODE_STATUS;
        end
      end else begin
        unique case (kind)
          K_SETUP: begin
            pending_d = 1'b1;
            mode_d    = MODE_STATUS;
          end
          K_RD_ARRAY:   mode_d  = MODE_ARRAY;
          K_RD_STATUS:  mode_d  = MODE_STATUS;
          K_CLR_STATUS: clr_err = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      mode    <= MODE_ARRAY;
    end else begin
      pending <= pending_d;
      mode    <= mode_d;
    end
  end

endmodule

// File: rtl/bcr_cfg_store.sv
module bcr_cfg_store
  import bcr_pkg::*;
#(
  parameter logic [CFG_W-1:0] CFG_RESET = 16'hB807
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] value,
  output logic [CFG_W-1:0] cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n)    cfg <= CFG_RESET;
    else if (load) cfg <= value;
  end

endmodule

// File: rtl/bcr_status_unit.sv
module bcr_status_unit
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_err,
  input  logic              clr_err,
  output logic [DATA_W-1:0] status
);

  logic [STS_ERR_N-1:0] err_q;

  generate
    for (genvar g = 0; g < STS_ERR_N; g++) begin : g_err
      always_ff @(posedge clk) begin
        if (!rst_n)       err_q[g] <= 1'b0;
        else if (set_err) err_q[g] <= 1'b1;
        else if (clr_err) err_q[g] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    status = '0;
    status[STS_READY_POS] = 1'b1;
    status[STS_ERR_LO +: STS_ERR_N] = err_q;
  end

endmodule

// File: rtl/bcr_writer.sv
module bcr_writer
  import bcr_pkg::*;
#(
  parameter int                ADDR_W       = 20,
  parameter logic [CFG_W-1:0]  CFG_RESET    = 16'hB807,
  parameter logic [DATA_W-1:0] CODE_SETUP   = 8'h60,
  parameter logic [DATA_W-1:0] CODE_CONFIRM = 8'h03,
  parameter logic [DATA_W-1:0] CODE_RD_ARR  = 8'hFF,
  parameter logic [DATA_W-1:0] CODE_RD_STS  = 8'h70,
  parameter logic [DATA_W-1:0] CODE_CLR_STS = 8'h50
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     wr_addr,
  output logic [CFG_W-1:0]      cfg_word,
  output logic [LEN_W-1:0]      burst_len,
  output logic                  burst_wrap,
  output logic [YLAT_W-1:0]     y_lat,
  output logic [XLAT_W-1:0]     x_lat,
  output logic                  async_rd,
  output logic [DATA_W-1:0]     status,
  output logic                  rd_status_sel
);

  localparam int HI_W = ADDR_W - CFG_W;

  cmd_kind_e kind;
  rd_mode_e  mode;
  logic      seq_pending;
  logic      load_cfg;
  logic      set_err;
  logic      clr_err;
  logic      unused_addr_hi;

  assign unused_addr_hi = ^wr_addr[ADDR_W-1 -: HI_W];

  bcr_cmd_decode #(
    .CODE_SETUP  (CODE_SETUP),
    .CODE_CONFIRM(CODE_CONFIRM),
    .CODE_RD_ARR (CODE_RD_ARR),
    .CODE_RD_STS (CODE_RD_STS),
    .CODE_CLR_STS(CODE_CLR_STS)
  ) u_dec (
    .code(wr_data),
    .kind(kind)
  );

  bcr_seq_fsm u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .kind    (kind),
    .pending (seq_pending),
    .mode    (mode),
    .load_cfg(load_cfg),
    .set_err (set_err),
    .clr_err (clr_err)
  );

  bcr_cfg_store #(.CFG_RESET(CFG_RESET)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_cfg),
    .value(wr_addr[CFG_W-1:0]),
    .cfg  (cfg_word)
  );

  bcr_status_unit u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_err(set_err),
    .clr_err(clr_err),
    .status (status)
  );

  assign burst_len     = cfg_word[LEN_LO +: LEN_W];
  assign burst_wrap    = cfg_word[WRAP_POS];
  assign y_lat         = cfg_word[YLAT_LO +: YLAT_W];
  assign x_lat         = cfg_word[XLAT_LO +: XLAT_W];
  assign async_rd      = cfg_word[ASYNC_POS];
  assign rd_status_sel = (mode == MODE_STATUS);

endmodule

// File: rtl/bcr_writer_checker.sv
module bcr_writer_checker
  import bcr_pkg::*;
#(
  parameter int                ADDR_W       = 20,
  parameter logic [DATA_W-1:0] CODE_CONFIRM = 8'h03,
  parameter logic [DATA_W-1:0] CODE_CLR_STS = 8'h50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CFG_W-1:0]  cfg_word,
  input logic [DATA_W-1:0] status,
  input logic              rd_status_sel,
  input logic              seq_pending
);

  logic confirm_hit;
  logic abort_hit;
  logic clear_hit;
  assign confirm_hit = wr_en && seq_pending && (wr_data == CODE_CONFIRM);
  assign abort_hit   = wr_en && seq_pending && (wr_data != CODE_CONFIRM);
  assign clear_hit   = wr_en && !seq_pending && (wr_data == CODE_CLR_STS);

  assert_load_from_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_hit |=> cfg_word == $past(wr_addr[CFG_W-1:0]));

  assert_back_to_array_R4: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_hit |=> !rd_status_sel && !seq_pending);

  assert_abort_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> status[5] && status[4] && rd_status_sel && $stable(cfg_word));

  assert_cfg_only_on_confirm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !confirm_hit |=> $stable(cfg_word));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clear_hit) |=> status[5] && status[4]);

  assert_idle_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(seq_pending) && $stable(rd_status_sel) && $stable(status));

endmodule

bind bcr_writer bcr_writer_checker #(
  .ADDR_W      (ADDR_W),
  .CODE_CONFIRM(CODE_CONFIRM),
  .CODE_CLR_STS(CODE_CLR_STS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .wr_addr      (wr_addr),
  .cfg_word     (cfg_word),
  .status       (status),
  .rd_status_sel(rd_status_sel),
  .seq_pending  (seq_pending)
);

// File: tb/bcr_writer_test.sv
module bcr_writer_test;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [15:0]       cfg_word;
  logic [2:0]        burst_len;
  logic              burst_wrap;
  logic [1:0]        y_lat;
  logic [3:0]        x_lat;
  logic              async_rd;
  logic [7:0]        status;
  logic              rd_status_sel;

  int n_vec = 0;
  int n_bad = 0;

  logic [15:0] m_cfg;
  logic        m_err;
  logic        m_mode;
  logic        m_pend;

  always #10 clk = ~clk;

  bcr_writer #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_addr(wr_addr), .cfg_word(cfg_word), .burst_len(burst_len),
    .burst_wrap(burst_wrap), .y_lat(y_lat), .x_lat(x_lat),
    .async_rd(async_rd), .status(status), .rd_status_sel(rd_status_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] exp_sts;
    exp_sts = {1'b1, 1'b0, m_err, m_err, 4'b0000};
    chk({tag, " cfg"}, 32'(cfg_word), 32'(m_cfg));
    chk({tag, " status R6"}, 32'(status), 32'(exp_sts));
    chk({tag, " mode"}, 32'(rd_status_sel), 32'(m_mode));
    chk("R9 fields", {15'd0, async_rd, x_lat, y_lat, burst_wrap, burst_len},
        {15'd0, m_cfg[15], m_cfg[14:11], m_cfg[10:9], m_cfg[3], m_cfg[2:0]});
  endtask

  // One bus write; model follows the requirements, then outputs are compared
  task automatic bus_wr(input logic [7:0] d, input logic [ADDR_W-1:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_pend) begin
      m_pend = 1'b0;
      if (d == 8'h03) begin m_cfg = a[15:0]; m_mode = 1'b0; end
      else begin m_err = 1'b1; m_mode = 1'b1; end
    end else begin
      case (d)
        8'h60: begin m_pend = 1'b1; m_mode = 1'b1; end
        8'hFF: m_mode = 1'b0;
        8'h70: m_mode = 1'b1;
        8'h50: m_err = 1'b0;
        default: ;
      endcase
    end
    compare_all(tag);
  endtask

  function automatic logic [ADDR_W-1:0] mix(input int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E3779B1 + 32'h5A5A1234;
    return v[ADDR_W-1:0];
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_cfg = 16'hB807; m_err = 1'b0; m_mode = 1'b0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 reset");
    chk("R1 async after reset", 32'(async_rd), 32'd1);

    // Sweep every code in the idle state (R8, R10, R2)
    for (int c = 0; c < 256; c++) begin
      bus_wr(8'(c), mix(c), "R8 idle code");
      if (m_pend) bus_wr(8'h03, mix(c + 1000), "R3 confirm after R2 setup");
    end

    // Sweep every code as the second write of a sequence (R3, R5)
    for (int c = 0; c < 256; c++) begin
      bus_wr(8'h60, mix(c + 7), "R2 setup");
      bus_wr(8'(c), mix(c + 300), "R5 R3 second write");
      if (m_err) begin
        bus_wr(8'h60, mix(c + 9), "R6 setup with flags set");
        bus_wr(8'h03, mix(c + 600), "R6 flags persist over load");
        bus_wr(8'h50, mix(c), "R6 clear");
      end
    end

    // Walking-one addresses including ignored high bits (R3)
    for (int b = 0; b < ADDR_W; b++) begin
      bus_wr(8'h60, '0, "R2 setup");
      bus_wr(8'h03, ADDR_W'(1) << b, "R3 walking bit");
      bus_wr(8'h70, '0, "R10 status mode");
      bus_wr(8'hFF, '0, "R10 array mode");
    end

    // Idle gap inside a sequence (R7), then confirm (R4)
    bus_wr(8'h60, '0, "R2 setup");
    repeat (7) @(negedge clk);
    compare_all("R7 idle gap");
    bus_wr(8'h03, 20'hF1234, "R4 confirm after gap");
    chk("R4 array mode", 32'(rd_status_sel), 32'd0);

    // Clear while pending is not a clear: it aborts (R5, R6)
    bus_wr(8'h60, '0, "R2 setup");
    bus_wr(8'h50, 20'h0FFFF, "R5 clear code as confirm");
    repeat (4) @(negedge clk);
    compare_all("R7 flags held idle");
    bus_wr(8'h50, '0, "R6 clear idle");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule